// File: doc/BRIEF.md
# Priority Pin-Assignment Crossbar

This block connects a fixed, ordered list of peripheral signals to the pins of two 16-pin port banks. The allocation is greedy. The block walks the signal list from first to last. Each signal whose group is switched on takes the lowest-numbered pin that is inside the instance's pin window, is not marked as skipped, and has not already been taken by an earlier signal. A peripheral's signals sit next to each other in the list, so a peripheral that comes earlier always lands on lower pins than one that comes later.

Software drives the block through a small write port with six addresses. Two addresses write the low and high words of a 64-bit group-enable word. Two addresses write the per-bank skip masks. One address holds the global enable, and one address clears the sticky overflow flag.

For every pin the block reports which signal it carries, with a valid flag. A pin whose valid flag is low is left to the port's GPIO function. For every signal the block reports the pin it received and whether it was placed. Signals are numbered from 0 in list order, and pins are numbered 0 to 31, where pin 16·b+i is pin i of bank b. Allocation is recomputed every cycle from the stored settings, and the result is registered, so a change of setting appears at the outputs one clock after it is stored.

Top module: `pin_xbar`

## Requirements
- R1: After reset the global enable is off, every group enable and skip bit is 0, and `pinValid`, `sigPlaced` and `overflow` are all 0.
- R2: With the global enable on, signal s of every enabled group receives the lowest pin not skipped, not outside the window and not taken by a signal with a lower index. For that pin, `pinValid` is 1 and `pinSel` holds s. For that signal, `sigPlaced` is 1 and `sigPin` holds the pin. `pinSel` and `sigPin` read 0 where their valid or placed flag is 0.
- R3: Writing address 2 stores bank 0's skip mask from `wrData[15:0]`, and address 3 stores bank 1's mask. A 1 at bit i removes pin i of that bank from allocation. A change while the crossbar is enabled re-places all later signals.
- R4: With the default parameters there are 8 groups of sizes 2,2,1,2,2,1,3,1, giving 14 signals. Group g is enabled by bit 0,1,2,4,5,6,32,33 (for g=0..7) of the 64-bit enable word. Address 0 writes enable bits 31:0 and address 1 writes bits 63:32. One bit switches on all signals of its group.
- R5: Enable-word bits that belong to no group have no effect on any output.
- R6: When bit 0 of address 4 is 0, no pin is valid and no signal is placed, whatever the masks hold.
- R7: Pins below `FIRST_PIN` or above `LAST_PIN` are never assigned. With `FIRST_PIN`=6 and `LAST_PIN`=27, allocation covers bank 0 pin 6 through bank 1 pin 11.
- R8: A setting written at clock edge E is reflected at the outputs after edge E+1 and not before.
- R9: An enabled signal that finds no free pin sets `overflow`, which then stays 1 until it is cleared.
- R10: A write to address 5 clears `overflow` at that edge, even if a signal is still unplaced. If the shortage persists, the flag is set again one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address (0..5) |
| wrData | input | 32 | Register write data |
| pinSel | output | 128 | Per-pin signal index, 4 bits per pin, pin 0 in the low bits |
| pinValid | output | 32 | Per-pin flag: a signal is assigned |
| sigPin | output | 70 | Per-signal pin number, 5 bits per signal, signal 0 in the low bits |
| sigPlaced | output | 14 | Per-signal flag: a pin was found |
| overflow | output | 1 | Sticky flag: an enabled signal found no pin |

## Verification
The overflow flag can be set by a shortage of pins and cleared by software in the same cycle. The bench provokes this by skipping almost every pin with all groups on, so the shortage persists, and then writing the clear address. It expects `overflow` to read 0 just after the clear edge and 1 again one edge later. After the skip mask is relaxed, the flag must still read 1 until a second clear, and then 0 on two consecutive cycles. The placement itself is swept over all 256 group-enable combinations. Each combination is run with three skip patterns and with junk in the unmapped enable bits, on a full-range and a windowed instance at once, and compared against an arithmetic model of the greedy walk.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;

  typedef enum logic [2:0] {
    ADDR_EN_LO = 3'd0,
    ADDR_EN_HI = 3'd1,
    ADDR_SKIP0 = 3'd2,
    ADDR_SKIP1 = 3'd3,
    ADDR_CTRL  = 3'd4,
    ADDR_CLR   = 3'd5
  } regAddr_e;

  // strobes from the control side to the allocation datapath
  typedef struct packed {
    logic enable;
    logic clrOvf;
  } xbarCtl_t;

  // total signal count from per-group sizes, one nibble per group
  function automatic int sumSizes(input logic [63:0] sizes, input int n);
    int acc;
    acc = 0;
    for (int g = 0; g < n; g++) acc += int'(sizes[g*4 +: 4]);
    return acc;
  endfunction

  // group that owns list position s
  function automatic int groupOf(input logic [63:0] sizes, input int n, input int s);
    int acc;
    acc = 0;
    for (int g = 0; g < n; g++) begin
      acc += int'(sizes[g*4 +: 4]);
      if (s < acc) return g;
    end
    return n - 1;
  endfunction

endpackage

// File: rtl/pin_xbar_ctrl.sv
module pin_xbar_ctrl
  import pin_xbar_pkg::*;
#(
  parameter int NUM_GRP   = 8,
  parameter logic [8*NUM_GRP-1:0] GRP_BIT = 64'h2120_0605_0402_0100,
  parameter int NUM_BANKS = 2,
  parameter int BANK_PINS = 16,
  localparam int NUM_PINS = NUM_BANKS * BANK_PINS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          wrAddr,
  input  logic [31:0]         wrData,
  output logic [NUM_GRP-1:0]  grpOn,
  output logic [NUM_PINS-1:0] skipMask,
  output xbarCtl_t            ctl
);

  logic enableQ;
  logic unusedWr;

  assign unusedWr = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enableQ <= 1'b0;
    else if (wrEn && wrAddr == ADDR_CTRL) enableQ <= wrData[0];
  end

  assign ctl.enable = enableQ;
  assign ctl.clrOvf = wrEn && (wrAddr == ADDR_CLR);

  // one enable flop per group, at the word/bit its parameter names
  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrp
    localparam int BITPOS = int'(GRP_BIT[g*8 +: 8]);
    localparam logic [2:0] WADDR = (BITPOS < 32) ? ADDR_EN_LO : ADDR_EN_HI;
    localparam int LBIT = BITPOS % 32;
    logic onQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) onQ <= 1'b0;
      else if (wrEn && wrAddr == WADDR) onQ <= wrData[LBIT];
    end
    assign grpOn[g] = onQ;
  end

  // skip mask per bank, consecutive addresses from the first bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    localparam logic [2:0] SADDR = 3'(int'(ADDR_SKIP0) + b);
    logic [BANK_PINS-1:0] skipQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) skipQ <= '0;
      else if (wrEn && wrAddr == SADDR) skipQ <= wrData[BANK_PINS-1:0];
    end
    assign skipMask[b*BANK_PINS +: BANK_PINS] = skipQ;
  end

  AST_CTRL_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_CTRL && !wrData[0]) |=> !ctl.enable); // R6

endmodule

// File: rtl/pin_xbar_alloc.sv
module pin_xbar_alloc
  import pin_xbar_pkg::*;
#(
  parameter int NUM_GRP   = 8,
  parameter logic [4*NUM_GRP-1:0] GRP_SIZE = 32'h1312_2122,
  parameter int NUM_PINS  = 32,
  parameter int FIRST_PIN = 0,
  parameter int LAST_PIN  = 31,
  localparam int NUM_SIG  = sumSizes(64'(GRP_SIZE), NUM_GRP),
  localparam int SIG_W    = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1,
  localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_GRP-1:0]        grpOn,
  input  logic [NUM_PINS-1:0]       skipMask,
  input  xbarCtl_t                  ctl,
  output logic [NUM_PINS*SIG_W-1:0] pinSelQ,
  output logic [NUM_PINS-1:0]       pinValidQ,
  output logic [NUM_SIG*PIN_W-1:0]  sigPinQ,
  output logic [NUM_SIG-1:0]        sigPlacedQ,
  output logic                      overflowQ
);

  function automatic logic [NUM_PINS-1:0] windowMask();
    logic [NUM_PINS-1:0] m;
    for (int p = 0; p < NUM_PINS; p++) m[p] = (p >= FIRST_PIN) && (p <= LAST_PIN);
    return m;
  endfunction

  localparam logic [NUM_PINS-1:0] WINDOW = windowMask();

  logic [NUM_SIG-1:0] sigOn;

  for (genvar s = 0; s < NUM_SIG; s++) begin : gSig
    localparam int GRP = groupOf(64'(GRP_SIZE), NUM_GRP, s);
    assign sigOn[s] = grpOn[GRP];
  end

  logic [NUM_PINS-1:0]       availD;
  logic [NUM_PINS*SIG_W-1:0] pinSelD;
  logic [NUM_PINS-1:0]       pinValidD;
  logic [NUM_SIG*PIN_W-1:0]  sigPinD;
  logic [NUM_SIG-1:0]        placedD;
  logic [NUM_SIG-1:0]        unplacedD;
  logic                      found;

  // greedy walk: list order, lowest free pin first
  always_comb begin
    availD    = WINDOW & ~skipMask;
    pinSelD   = '0;
    pinValidD = '0;
    sigPinD   = '0;
    placedD   = '0;
    unplacedD = '0;
    found     = 1'b0;
    for (int s = 0; s < NUM_SIG; s++) begin
      found = 1'b0;
      if (ctl.enable && sigOn[s]) begin
        for (int p = 0; p < NUM_PINS; p++) begin
          if (!found && availD[p]) begin
            found = 1'b1;
            availD[p] = 1'b0;
            pinValidD[p] = 1'b1;
            pinSelD[p*SIG_W +: SIG_W] = SIG_W'(s);
            sigPinD[s*PIN_W +: PIN_W] = PIN_W'(p);
          end
        end
        placedD[s]   = found;
        unplacedD[s] = !found;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinSelQ    <= '0;
      pinValidQ  <= '0;
      sigPinQ    <= '0;
      sigPlacedQ <= '0;
    end else begin
      pinSelQ    <= pinSelD;
      pinValidQ  <= pinValidD;
      sigPinQ    <= sigPinD;
      sigPlacedQ <= placedD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overflowQ <= 1'b0;
    else if (ctl.clrOvf) overflowQ <= 1'b0;
    else if (|unplacedD) overflowQ <= 1'b1;
  end

  // consistency of the registered results, for the checks below
  logic orderOk;
  logic backOk;
  always_comb begin
    orderOk = 1'b1;
    for (int s = 0; s < NUM_SIG; s++)
      for (int t = s + 1; t < NUM_SIG; t++)
        if (sigPlacedQ[s] && sigPlacedQ[t] &&
            sigPinQ[s*PIN_W +: PIN_W] >= sigPinQ[t*PIN_W +: PIN_W])
          orderOk = 1'b0;
  end
  always_comb begin
    backOk = 1'b1;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (pinValidQ[p]) begin
        if (int'(pinSelQ[p*SIG_W +: SIG_W]) >= NUM_SIG) backOk = 1'b0;
        else if (!sigPlacedQ[pinSelQ[p*SIG_W +: SIG_W]] ||
                 int'(sigPinQ[pinSelQ[p*SIG_W +: SIG_W]*PIN_W +: PIN_W]) != p)
          backOk = 1'b0;
      end
    end
  end

  AST_LIST_ORDER: assert property (@(posedge clk) disable iff (!rstN) orderOk); // R2
  AST_PIN_BACKREF: assert property (@(posedge clk) disable iff (!rstN) backOk); // R2
  AST_SKIP_HONORED: assert property (@(posedge clk) disable iff (!rstN)
    ((pinValidQ & $past(skipMask)) == '0)); // R3
  AST_DISABLED_DARK: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.enable |=> (pinValidQ == '0 && sigPlacedQ == '0)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflowQ && !ctl.clrOvf) |=> overflowQ); // R9
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrOvf |=> !overflowQ); // R10

endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NUM_GRP   = 8,
  parameter logic [4*NUM_GRP-1:0] GRP_SIZE = 32'h1312_2122,
  parameter logic [8*NUM_GRP-1:0] GRP_BIT  = 64'h2120_0605_0402_0100,
  parameter int NUM_BANKS = 2,
  parameter int BANK_PINS = 16,
  parameter int FIRST_PIN = 0,
  parameter int LAST_PIN  = 31,
  localparam int NUM_PINS = NUM_BANKS * BANK_PINS,
  localparam int NUM_SIG  = sumSizes(64'(GRP_SIZE), NUM_GRP),
  localparam int SIG_W    = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1,
  localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [2:0]                wrAddr,
  input  logic [31:0]               wrData,
  output logic [NUM_PINS*SIG_W-1:0] pinSel,
  output logic [NUM_PINS-1:0]       pinValid,
  output logic [NUM_SIG*PIN_W-1:0]  sigPin,
  output logic [NUM_SIG-1:0]        sigPlaced,
  output logic                      overflow
);

  logic [NUM_GRP-1:0]  grpOn;
  logic [NUM_PINS-1:0] skipMask;
  xbarCtl_t            ctl;

  pin_xbar_ctrl #(
    .NUM_GRP  (NUM_GRP),
    .GRP_BIT  (GRP_BIT),
    .NUM_BANKS(NUM_BANKS),
    .BANK_PINS(BANK_PINS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .grpOn   (grpOn),
    .skipMask(skipMask),
    .ctl     (ctl)
  );

  pin_xbar_alloc #(
    .NUM_GRP  (NUM_GRP),
    .GRP_SIZE (GRP_SIZE),
    .NUM_PINS (NUM_PINS),
    .FIRST_PIN(FIRST_PIN),
    .LAST_PIN (LAST_PIN)
  ) u_alloc (
    .clk       (clk),
    .rstN      (rstN),
    .grpOn     (grpOn),
    .skipMask  (skipMask),
    .ctl       (ctl),
    .pinSelQ   (pinSel),
    .pinValidQ (pinValid),
    .sigPinQ   (sigPin),
    .sigPlacedQ(sigPlaced),
    .overflowQ (overflow)
  );

endmodule

// File: tb/pin_xbar_tb.sv
`timescale 1ns/1ps
module pin_xbar_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;

  logic [127:0] selA, selB;
  logic [31:0]  valA, valB;
  logic [69:0]  spA, spB;
  logic [13:0]  plA, plB;
  logic         ovA, ovB;

  int nTests = 0;
  int nFail  = 0;

  // bench shadow of the written settings
  logic [63:0] shMask = '0;
  logic [31:0] shSkip = '0;
  logic        shEn   = 1'b0;

  localparam int GSZ[8]  = '{2, 2, 1, 2, 2, 1, 3, 1};
  localparam int GBIT[8] = '{0, 1, 2, 4, 5, 6, 32, 33};

  always #2 clk = ~clk;

  pin_xbar u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinSel(selA), .pinValid(valA), .sigPin(spA), .sigPlaced(plA), .overflow(ovA)
  );

  pin_xbar #(.FIRST_PIN(6), .LAST_PIN(27)) u_dutWin (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinSel(selB), .pinValid(valB), .sigPin(spB), .sigPlaced(plB), .overflow(ovB)
  );

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      3'd0: shMask[31:0]  = d;
      3'd1: shMask[63:32] = d;
      3'd2: shSkip[15:0]  = d[15:0];
      3'd3: shSkip[31:16] = d[15:0];
      3'd4: shEn          = d[0];
      default: ;
    endcase
  endtask

  // arithmetic model of the greedy placement
  task automatic model(input int first, input int last, output logic [31:0] v,
                       output logic [127:0] sel, output logic [69:0] sp,
                       output logic [13:0] pl, output bit short);
    logic [31:0] avail;
    int s;
    v = '0; sel = '0; sp = '0; pl = '0; short = 1'b0; s = 0;
    for (int p = 0; p < 32; p++) avail[p] = (p >= first) && (p <= last) && !shSkip[p];
    for (int g = 0; g < 8; g++) begin
      for (int k = 0; k < GSZ[g]; k++) begin
        if (shEn && shMask[GBIT[g]]) begin
          bit got;
          got = 1'b0;
          for (int p = 0; p < 32; p++) begin
            if (!got && avail[p]) begin
              got = 1'b1; avail[p] = 1'b0; v[p] = 1'b1;
              sel[p*4 +: 4] = 4'(s); sp[s*5 +: 5] = 5'(p); pl[s] = 1'b1;
            end
          end
          if (!got) short = 1'b1;
        end
        s++;
      end
    end
  endtask

  task automatic checkBoth(input string req);
    logic [31:0] v; logic [127:0] sel; logic [69:0] sp; logic [13:0] pl; bit sh;
    model(0, 31, v, sel, sp, pl, sh);
    check(valA == v && selA == sel && spA == sp && plA == pl, {req, " full"},
          {valA, selA, spA, plA}, {v, sel, sp, pl});
    model(6, 27, v, sel, sp, pl, sh);
    check(valB == v && selB == sel && spB == sp && plB == pl, {req, " window"},
          {valB, selB, spB, plB}, {v, sel, sp, pl});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] lo, hi;
    logic [31:0] skipPat[3];
    skipPat[0] = 32'h0000_0000;
    skipPat[1] = 32'h0005_0A41;
    skipPat[2] = 32'hFF00_0F0F;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(valA == 0 && plA == 0 && !ovA, "R1 reset full", {valA, plA, ovA}, 0);
    check(valB == 0 && plB == 0 && !ovB, "R1 reset window", {valB, plB, ovB}, 0);

    // R6 masks set but global enable off
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    @(negedge clk);
    check(valA == 0 && plA == 0, "R6 disabled full", {valA, plA}, 0);
    check(valB == 0 && plB == 0, "R6 disabled window", {valB, plB}, 0);

    // R8 enable lands one edge after it is stored
    wr(3'd4, 32'h1);
    check(valA == 0, "R8 not before E+1", valA, 0);
    @(negedge clk);
    check(valA == 32'h0000_3FFF, "R8 after E+1", valA, 32'h0000_3FFF);
    checkBoth("R2 all groups");

    // R6 disable again while placed
    wr(3'd4, 32'h0);
    @(negedge clk);
    check(valA == 0 && valB == 0, "R6 switched off", {valA, valB}, 0);
    wr(3'd4, 32'h1);

    // sweep: R2 R3 R4 R5 R7
    for (int c = 0; c < 256; c++) begin
      for (int k = 0; k < 3; k++) begin
        lo = {25'd0, c[5], c[4], c[3], 1'b0, c[2], c[1], c[0]};
        hi = {30'd0, c[7], c[6]};
        if (c[0]) begin  // R5 junk in bits that belong to no group
          lo = lo | 32'hFFFF_0088;
          hi = hi | 32'hFFFF_FFFC;
        end
        wr(3'd0, lo);
        wr(3'd1, hi);
        wr(3'd2, {16'd0, skipPat[k][15:0]});
        wr(3'd3, {16'd0, skipPat[k][31:16]});
        @(negedge clk);
        checkBoth("R2 R3 R4 R5 R7 sweep");
      end
    end

    // R3 skip change while enabled shifts later signals
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h0);
    @(negedge clk);
    wr(3'd2, 32'h0000_0001);
    @(negedge clk);
    check(valA == 32'h0000_7FFE && spA[4:0] == 5'd1, "R3 shift", {valA, spA},
          {32'h0000_7FFE, 5'd1});
    checkBoth("R3 shift model");

    // R9 / R10 overflow
    wr(3'd5, 32'h0);
    @(negedge clk);
    check(!ovA && !ovB, "R10 initial clear", {ovA, ovB}, 0);
    wr(3'd2, 32'hFFF0);
    wr(3'd3, 32'hFFFF);
    @(negedge clk);
    check(ovA && ovB, "R9 shortage sets", {ovA, ovB}, 2'b11);
    check(valA == 32'h0000_000F && valB == 0, "R7 window starved", {valA, valB},
          {32'h0000_000F, 32'h0});
    wr(3'd5, 32'h0);
    check(!ovA && !ovB, "R10 clear wins at its edge", {ovA, ovB}, 0);
    @(negedge clk);
    check(ovA && ovB, "R10 set again next edge", {ovA, ovB}, 2'b11);
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h0);
    @(negedge clk);
    @(negedge clk);
    check(ovA && ovB, "R9 sticky after relief", {ovA, ovB}, 2'b11);
    wr(3'd5, 32'h0);
    check(!ovA && !ovB, "R10 cleared", {ovA, ovB}, 0);
    @(negedge clk);
    check(!ovA && !ovB, "R10 stays clear", {ovA, ovB}, 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule